// File: doc/BRIEF.md
# Multi-Source Interrupt Gather Register

The block gathers up to eight edge-type interrupt inputs behind one byte-wide register at a single bus offset. A write to that offset loads the per-source enable mask. A read returns which enabled sources have caught an event. A single registered request line is high while any caught event is outstanding. Sources that are not fitted on a given build are removed through a parameter mask: they never latch, and they always read as zero.

There is no acknowledge register. Software clears an event by writing the mask with that source's bit at 0, and it re-arms the source by writing the bit back to 1. A service routine can therefore loop: read the status, disable what it saw, read again. Events that arrive on sources that are still enabled while it does this are caught and show up on the next read.

Each fitted source is a three-state machine. SRC_OFF means disabled. SRC_ARMED means enabled and waiting. SRC_PENDING means an event has been caught. The transitions are: OFF to ARMED on a register write with the bit at 1. ARMED to PENDING on a rising input edge. ARMED to OFF and PENDING to OFF on a register write with the bit at 0. A write with the bit at 1 leaves ARMED and PENDING as they are. The request line is a two-state machine. IRQ_IDLE goes to IRQ_RAISED when any source is pending, and IRQ_RAISED goes back to IRQ_IDLE when none is.

Top module: `irq_gather_reg`

## Requirements
- R1: Reset, which is asynchronous and active low, puts every source in the disabled state with no pending event and drives irq to 0. After reset, an input edge is not latched until a write enables its source.
- R2: A write to address 0x1E sets the enable mask to wdata ANDed with VALID_MASK. On a fitted source that is enabled, a rising edge on its input sets its pending bit. Bit i of rdata is the pending bit of source i.
- R3: A rising edge on a source whose enable bit is 0 leaves its pending bit at 0.
- R4: Only a 0-to-1 transition of the input (the input high in a cycle and low in the previous cycle) latches an event. A level held high across a re-arm latches nothing, and neither does a falling edge.
- R5: A write with a source's enable bit at 0 clears that source's pending bit. irq falls one cycle after the last pending bit clears.
- R6: Writing the enable bit back to 1 re-arms a cleared source, so that a later rising edge latches again. Rewriting 1 to a source that is already pending keeps its pending bit.
- R7: Sources whose VALID_MASK bit is 0 never latch and always read 0 (default VALID_MASK 8'h3F, so bits 7 and 6 read 0).
- R8: irq is registered: after the clock edge that ends cycle k, it equals the OR of the pending bits as they stood during cycle k.
- R9: While some sources are being disabled by a write, an edge in that same cycle on a source that stays enabled is latched. It is visible on the next read.
- R10: An edge on a source in the same cycle as the write that disables it is dropped.
- R11: A write to any address other than 0x1E leaves the enables unchanged. rdata is 0 unless rd_en is high and addr is 0x1E.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 5 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Enable mask to write |
| rdata | output | 8 | Pending status, masked by fitted sources |
| src_in | input | 8 | Interrupt source inputs, synchronous to clk |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench works through the service loop with the corner cases that loop exposes.

- **Late edge during a disable write.** An edge arrives on a still-enabled source in the same cycle that another source is disabled. A design that cleared everything on a write would lose this event.
- **Edge on the source being disabled.** A design that gave the edge priority over the disable would leave a stray pending bit.
- **Input held high across a disable and re-arm.** A level-sensitive latch would fire again here and cause an interrupt storm.
- **Invalid sources.** Edges on the unfitted bits 7 and 6 are checked. A missing mask would make them read as 1.
- **Request timing.** The request line is checked one cycle behind the status. An unregistered or stuck request would show up as a mismatch.

// File: rtl/irqg_pkg.sv
package irqg_pkg;

    typedef enum logic [1:0] {
        SRC_OFF     = 2'd0,
        SRC_ARMED   = 2'd1,
        SRC_PENDING = 2'd2
    } src_state_t;

    typedef enum logic {
        IRQ_IDLE   = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_t;

endpackage

// File: rtl/irqg_decode.sv
module irqg_decode #(
    parameter int               ADDR_W   = 5,
    parameter logic [ADDR_W-1:0] REG_ADDR = 5'h1E
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic              wr_hit,
    output logic              rd_hit
);
    logic sel;

    always_comb begin
        sel    = (addr == REG_ADDR);
        wr_hit = wr_en && sel;
        rd_hit = rd_en && sel;
    end
endmodule

// File: rtl/irqg_edge.sv
module irqg_edge #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] rise
);
    logic [WIDTH-1:0] din_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) din_q <= '0;
        else        din_q <= din;
    end

    always_comb rise = din & ~din_q;
endmodule

// File: rtl/irqg_src_cell.sv
module irqg_src_cell
    import irqg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_hit,
    input  logic en_bit,
    input  logic rise,
    output logic enabled,
    output logic pending
);
    src_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            SRC_OFF:     if (wr_hit && en_bit)  state_nx = SRC_ARMED;
            SRC_ARMED:   if (wr_hit && !en_bit) state_nx = SRC_OFF;
                         else if (rise)         state_nx = SRC_PENDING;
            SRC_PENDING: if (wr_hit && !en_bit) state_nx = SRC_OFF;
            default:                            state_nx = SRC_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SRC_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        enabled = (state != SRC_OFF);
        pending = (state == SRC_PENDING);
    end
endmodule

// File: rtl/irqg_req_fsm.sv
module irqg_req_fsm
    import irqg_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pending,
    output logic             irq
);
    irq_state_t state, state_nx;
    logic       any_pend;

    always_comb begin
        any_pend = |pending;
        state_nx = state;
        unique case (state)
            IRQ_IDLE:   if (any_pend)  state_nx = IRQ_RAISED;
            IRQ_RAISED: if (!any_pend) state_nx = IRQ_IDLE;
            default:                   state_nx = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= IRQ_IDLE;
        else        state <= state_nx;
    end

    always_comb irq = (state == IRQ_RAISED);
endmodule

// File: rtl/irq_gather_reg.sv
module irq_gather_reg #(
    parameter int                 NUM_SRC    = 8,
    parameter int                 ADDR_W     = 5,
    parameter logic [ADDR_W-1:0]  REG_ADDR   = 5'h1E,
    parameter logic [NUM_SRC-1:0] VALID_MASK = 8'h3F
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [NUM_SRC-1:0] wdata,
    output logic [NUM_SRC-1:0] rdata,
    input  logic [NUM_SRC-1:0] src_in,
    output logic               irq
);
    logic               wr_hit, rd_hit;
    logic [NUM_SRC-1:0] rise, enable, pending;

    irqg_decode #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) i_decode (
        .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wr_hit(wr_hit), .rd_hit(rd_hit)
    );

    irqg_edge #(.WIDTH(NUM_SRC)) i_edge (
        .clk(clk), .rst_n(rst_n), .din(src_in), .rise(rise)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        if (VALID_MASK[i]) begin : g_fit
            irqg_src_cell i_cell (
                .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit),
                .en_bit(wdata[i]), .rise(rise[i]),
                .enabled(enable[i]), .pending(pending[i])
            );
        end else begin : g_absent
            assign enable[i]  = 1'b0;
            assign pending[i] = 1'b0;
        end
    end

    irqg_req_fsm #(.WIDTH(NUM_SRC)) i_req (
        .clk(clk), .rst_n(rst_n), .pending(pending), .irq(irq)
    );

    always_comb rdata = rd_hit ? (pending & VALID_MASK) : '0;
endmodule

// File: rtl/irq_gather_reg_chk.sv
module irq_gather_reg_chk #(
    parameter int                 NUM_SRC    = 8,
    parameter int                 ADDR_W     = 5,
    parameter logic [ADDR_W-1:0]  REG_ADDR   = 5'h1E,
    parameter logic [NUM_SRC-1:0] VALID_MASK = 8'h3F
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  addr,
    input logic               rd_en,
    input logic               wr_hit,
    input logic [NUM_SRC-1:0] wdata,
    input logic [NUM_SRC-1:0] rdata,
    input logic [NUM_SRC-1:0] rise,
    input logic [NUM_SRC-1:0] enable,
    input logic [NUM_SRC-1:0] pending,
    input logic               irq
);
    AST_ENABLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> enable == ($past(wdata) & VALID_MASK)); // R2

    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (pending & ~$past(wdata)) == '0); // R5

    AST_LATCH_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (pending & ~$past(pending) & ~($past(rise) & $past(enable))) == '0); // R4

    AST_IRQ_REGISTERED: assert property (@(posedge clk) disable iff (!rst_n)
        irq == $past(|pending)); // R8

    AST_ABSENT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata & ~VALID_MASK) == '0); // R7

    AST_READ_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && addr == REG_ADDR) |-> rdata == '0); // R11
endmodule

bind irq_gather_reg irq_gather_reg_chk #(
    .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .VALID_MASK(VALID_MASK)
) i_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_hit(wr_hit),
    .wdata(wdata), .rdata(rdata), .rise(rise), .enable(enable),
    .pending(pending), .irq(irq)
);

// File: tb/test_irq_gather_reg.sv
module test_irq_gather_reg;
    localparam logic [4:0] REG = 5'h1E;
    localparam int         NV  = 34;

    // vector: {wr, wdata[7:0], src[7:0], exp_rdata[7:0], exp_irq, req[3:0]}
    localparam logic [29:0] TABLE [NV] = '{
        {1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 4'd1},  // R1 idle after reset
        {1'b1, 8'hFF, 8'h00, 8'h00, 1'b0, 4'd2},  // R2 enable all
        {1'b0, 8'h00, 8'h01, 8'h00, 1'b0, 4'd2},  // R2 edge bit0
        {1'b0, 8'h00, 8'h01, 8'h01, 1'b0, 4'd2},  // R2 latched
        {1'b0, 8'h00, 8'h00, 8'h01, 1'b1, 4'd8},  // R8 irq one cycle later
        {1'b0, 8'h00, 8'hC0, 8'h01, 1'b1, 4'd7},  // R7 edges on absent bits
        {1'b0, 8'h00, 8'h00, 8'h01, 1'b1, 4'd7},  // R7 absent bits read 0
        {1'b1, 8'h3E, 8'h00, 8'h00, 1'b1, 4'd5},  // R5 disable bit0
        {1'b0, 8'h00, 8'h00, 8'h00, 1'b1, 4'd5},  // R5 cleared, irq lags
        {1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 4'd5},  // R5 irq drops
        {1'b0, 8'h00, 8'h01, 8'h00, 1'b0, 4'd3},  // R3 edge while disabled
        {1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 4'd3},  // R3 nothing latched
        {1'b1, 8'h3F, 8'h00, 8'h00, 1'b0, 4'd6},  // R6 re-arm
        {1'b0, 8'h00, 8'h01, 8'h00, 1'b0, 4'd6},  // R6 new edge
        {1'b0, 8'h00, 8'h01, 8'h01, 1'b0, 4'd6},  // R6 latched again
        {1'b1, 8'h3F, 8'h01, 8'h00, 1'b1, 4'd6},  // R6 rewrite while pending
        {1'b0, 8'h00, 8'h00, 8'h01, 1'b1, 4'd6},  // R6 still pending
        {1'b0, 8'h00, 8'h02, 8'h01, 1'b1, 4'd4},  // R4 edge bit1
        {1'b0, 8'h00, 8'h02, 8'h03, 1'b1, 4'd4},  // R4 held high
        {1'b1, 8'h3C, 8'h02, 8'h00, 1'b1, 4'd4},  // R4 disable bits 0,1
        {1'b1, 8'h3F, 8'h02, 8'h00, 1'b1, 4'd4},  // R4 re-arm with level high
        {1'b0, 8'h00, 8'h02, 8'h00, 1'b0, 4'd4},  // R4 level not latched
        {1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 4'd4},  // R4 falling edge
        {1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 4'd4},  // R4 falling not latched
        {1'b1, 8'h3B, 8'h04, 8'h00, 1'b0, 4'd10}, // R10 edge with disable
        {1'b1, 8'h3F, 8'h04, 8'h00, 1'b0, 4'd10}, // R10 re-enable, level held
        {1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 4'd10}, // R10 edge was dropped
        {1'b0, 8'h00, 8'h08, 8'h00, 1'b0, 4'd9},  // R9 edge bit3
        {1'b0, 8'h00, 8'h00, 8'h08, 1'b0, 4'd9},  // R9 read sees bit3
        {1'b1, 8'h37, 8'h10, 8'h00, 1'b1, 4'd9},  // R9 disable bit3, bit4 arrives
        {1'b0, 8'h00, 8'h00, 8'h10, 1'b1, 4'd9},  // R9 late event caught
        {1'b1, 8'h27, 8'h00, 8'h00, 1'b1, 4'd9},  // R9 disable bit4
        {1'b1, 8'h3F, 8'h00, 8'h00, 1'b1, 4'd9},  // R9 restore mask
        {1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 4'd9}   // R9 all clear
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] addr = REG;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0, src_in = '0;
    logic [7:0] rdata;
    logic       irq;
    int         total = 0, bad = 0, cycles = 0;

    always #10 clk = ~clk;

    irq_gather_reg i_irq_gather_reg (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .src_in(src_in), .irq(irq)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 5000) begin
            bad   = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: act=%0d cycles exp<=5000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic w, input logic r, input logic [4:0] a,
                         input logic [7:0] d, input logic [7:0] s);
        @(negedge clk);
        wr_en = w; rd_en = r; addr = a; wdata = d; src_in = s;
        #8;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        chk("R1 irq in reset", {7'b0, irq}, 8'h00);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [29:0] v;
            v = TABLE[i];
            drive(v[29], !v[29], REG, v[28:21], v[20:13]);
            if (!v[29]) chk($sformatf("R%0d rdata step %0d", v[3:0], i), rdata, v[12:5]);
            chk($sformatf("R%0d irq step %0d", v[3:0], i), {7'b0, irq}, {7'b0, v[4]});
        end

        // R11: write elsewhere ignored, read elsewhere returns 0
        drive(1'b1, 1'b0, 5'h1D, 8'h00, 8'h00);
        drive(1'b0, 1'b1, 5'h1D, 8'h00, 8'h20);
        chk("R11 read other address", rdata, 8'h00);
        drive(1'b0, 1'b1, REG, 8'h00, 8'h00);
        chk("R11 enables kept after stray write", rdata, 8'h20);

        // R1: reset with an event pending
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b1; addr = REG; src_in = '0;
        #8;
        chk("R1 rdata in reset", rdata, 8'h00);
        chk("R1 irq in reset", {7'b0, irq}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b0, 1'b1, REG, 8'h00, 8'h01);
        drive(1'b0, 1'b1, REG, 8'h00, 8'h00);
        chk("R1 disabled after reset", rdata, 8'h00);
        drive(1'b0, 1'b1, REG, 8'h00, 8'h00);
        chk("R1 irq stays low", {7'b0, irq}, 8'h00);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule